// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This unit turns an addressing-mode code, an operand size, a base register value and a 4-bit displacement into the 32-bit memory address of a load or store. Post-increment and pre-decrement modes also produce a new value for the base register and a strobe that tells the register file to write it. The displacement mode scales the unsigned displacement by the operand size before it is added to the base. Register direct mode names a register as the operand, so it generates no memory access.

The inputs are captured in the cycle `in_valid` is high, and every result appears in the following cycle with `out_valid` high. A two-state machine tracks this. `ST_IDLE` means no result is presented. `ST_SHOW` means the registered result is valid. The transitions are:

- ACCEPT (`ST_IDLE` to `ST_SHOW`): taken when `in_valid` is high.
- STREAM (`ST_SHOW` to `ST_SHOW`): taken when a new input arrives back to back.
- DRAIN (`ST_SHOW` to `ST_IDLE`): taken when `in_valid` is low.

The address arithmetic wraps modulo 2^32. A misaligned flag and an error flag report an address that does not fit the operand size and reserved input codes.

Top module: `lsu_ea_gen`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. After reset it is 0, and every flag output is 0.
- R2: Mode code 0 (register direct) gives `mem_valid`=0, `wb_en`=0, `ea`=0 and `misaligned`=0.
- R3: Mode code 1 (register indirect) gives `ea`=base, `mem_valid`=1 and `wb_en`=0.
- R4: Mode code 2 (post-increment) gives `ea`=base, `mem_valid`=1, `wb_en`=1 and `wb_data`=base+step. The step is 1, 2 or 4 for size code 00 (byte), 01 (word) or 10 (longword).
- R5: Mode code 3 (pre-decrement) gives `ea`=base−step, `wb_data` equal to that same `ea`, `mem_valid`=1 and `wb_en`=1.
- R6: Mode code 4 (displacement) gives `ea`=base+(zero-extended disp shifted left by 0, 1 or 2 for byte, word or longword), `mem_valid`=1 and `wb_en`=0. The largest offsets are 15, 30 and 60.
- R7: All address sums and differences wrap modulo 2^32 with no flag.
- R8: `misaligned`=1 when `mem_valid`=1 and either the size is word with `ea[0]`=1, or the size is longword with `ea[1:0]`≠0. A byte access is never misaligned.
- R9: Size code 11 or mode codes 5 to 7 give `err`=1, with `mem_valid`, `wb_en` and `misaligned` all 0.
- R10: `mem_valid`, `wb_en`, `misaligned` and `err` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid; the inputs are captured in this cycle |
| mode | input | 3 | Addressing mode code (0 to 4) |
| size | input | 2 | Operand size code: 00 byte, 01 word, 10 longword |
| base | input | 32 | Base register contents |
| disp | input | 4 | Unsigned displacement |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| mem_valid | output | 1 | A memory access is required |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| wb_data | output | 32 | New base register value |
| misaligned | output | 1 | Address not a multiple of the operand size |
| err | output | 1 | Reserved size or mode code |

## Verification
The following are checked by assertions on every cycle:

- the one-cycle latency of `out_valid`;
- that the flags are silent while idle;
- that a writeback never occurs without an access;
- the post-increment relation between `wb_data` and `ea`;
- that pre-decrement writes back exactly the address used;
- the quiet outputs of register direct and reserved codes;
- that byte accesses are never misaligned.

The bench's scenarios show the rest:

- the exact addresses produced for each size;
- the largest scaled displacements;
- wraparound at both ends of the address space;
- misalignment detection for each size.

The bench also keeps a sixteen-entry register bank and uses it to show that a push sequence followed by a pop sequence returns the stack pointer to its starting value.

// File: rtl/lsu_ea_pkg.sv
package lsu_ea_pkg;

    typedef enum logic [2:0] {
        AM_DIRECT   = 3'd0,
        AM_INDIRECT = 3'd1,
        AM_POSTINC  = 3'd2,
        AM_PREDEC   = 3'd3,
        AM_DISP     = 3'd4
    } addr_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } op_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } ea_state_e;

endpackage

// File: rtl/lsu_ea_scale.sv
// Size-dependent step and scaled displacement.
module lsu_ea_scale #(
    parameter int AW     = 32,
    parameter int DISP_W = 4
) (
    input  logic [1:0]        size,
    input  logic [DISP_W-1:0] disp,
    output logic [AW-1:0]     step,
    output logic [AW-1:0]     offset,
    output logic              size_ok
);
    import lsu_ea_pkg::*;

    localparam int PAD_W = AW - DISP_W;

    logic [AW-1:0] disp_zx;

    assign disp_zx = {{PAD_W{1'b0}}, disp};
    assign size_ok = (size != SZ_RSVD);

    always_comb begin
        step   = '0;
        offset = '0;
        if (size_ok) begin
            step   = AW'(1) << size;
            offset = disp_zx << size;
        end
    end
endmodule

// File: rtl/lsu_ea_calc.sv
// Mode decode and address arithmetic.
module lsu_ea_calc #(
    parameter int AW = 32
) (
    input  logic [2:0]    mode,
    input  logic          size_ok,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] wb_data,
    output logic          mem_valid,
    output logic          wb_en,
    output logic          err
);
    import lsu_ea_pkg::*;

    logic mode_ok;

    assign mode_ok = (mode <= 3'(AM_DISP));
    assign err     = !(mode_ok && size_ok);

    always_comb begin
        ea        = '0;
        wb_data   = '0;
        mem_valid = 1'b0;
        wb_en     = 1'b0;
        if (!err) begin
            unique case (addr_mode_e'(mode))
                AM_DIRECT: begin
                end
                AM_INDIRECT: begin
                    ea        = base;
                    mem_valid = 1'b1;
                end
                AM_POSTINC: begin
                    ea        = base;
                    wb_data   = base + step;
                    mem_valid = 1'b1;
                    wb_en     = 1'b1;
                end
                AM_PREDEC: begin
                    ea        = base - step;
                    wb_data   = base - step;
                    mem_valid = 1'b1;
                    wb_en     = 1'b1;
                end
                AM_DISP: begin
                    ea        = base + offset;
                    mem_valid = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        AST_WB_IMPLIES_ACCESS: assert (!wb_en || mem_valid); // R4
    end
endmodule

// File: rtl/lsu_ea_align.sv
// Alignment check of the computed address against the operand size.
module lsu_ea_align #(
    parameter int AW = 32
) (
    input  logic [1:0]    size,
    input  logic          mem_valid,
    input  logic [AW-1:0] ea,
    output logic          misaligned
);
    import lsu_ea_pkg::*;

    always_comb begin
        misaligned = 1'b0;
        if (mem_valid) begin
            unique case (op_size_e'(size))
                SZ_BYTE: misaligned = 1'b0;
                SZ_WORD: misaligned = ea[0];
                SZ_LONG: misaligned = |ea[1:0];
                default: misaligned = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lsu_ea_gen.sv
// Top: input capture, result state machine and output registers.
module lsu_ea_gen #(
    parameter int AW     = 32,
    parameter int DISP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        mode,
    input  logic [1:0]        size,
    input  logic [AW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    output logic              out_valid,
    output logic [AW-1:0]     ea,
    output logic              mem_valid,
    output logic              wb_en,
    output logic [AW-1:0]     wb_data,
    output logic              misaligned,
    output logic              err
);
    import lsu_ea_pkg::*;

    ea_state_e     state_q, state_d;
    logic [AW-1:0] step_c, offset_c, ea_c, wb_data_c;
    logic          size_ok_c, mem_c, wb_c, err_c, mis_c;

    lsu_ea_scale #(.AW(AW), .DISP_W(DISP_W)) u_scale (
        .size    (size),
        .disp    (disp),
        .step    (step_c),
        .offset  (offset_c),
        .size_ok (size_ok_c)
    );

    lsu_ea_calc #(.AW(AW)) u_calc (
        .mode      (mode),
        .size_ok   (size_ok_c),
        .base      (base),
        .step      (step_c),
        .offset    (offset_c),
        .ea        (ea_c),
        .wb_data   (wb_data_c),
        .mem_valid (mem_c),
        .wb_en     (wb_c),
        .err       (err_c)
    );

    lsu_ea_align #(.AW(AW)) u_align (
        .size       (size),
        .mem_valid  (mem_c),
        .ea         (ea_c),
        .misaligned (mis_c)
    );

    // Next state: ACCEPT, STREAM, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea         <= '0;
            wb_data    <= '0;
            mem_valid  <= 1'b0;
            wb_en      <= 1'b0;
            misaligned <= 1'b0;
            err        <= 1'b0;
        end else if (in_valid) begin
            ea         <= ea_c;
            wb_data    <= wb_data_c;
            mem_valid  <= mem_c;
            wb_en      <= wb_c;
            misaligned <= mis_c;
            err        <= err_c;
        end else begin
            mem_valid  <= 1'b0;
            wb_en      <= 1'b0;
            misaligned <= 1'b0;
            err        <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_FLAGS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(mem_valid || wb_en || misaligned || err)); // R10
    AST_DIRECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'(AM_DIRECT) && size != 2'(SZ_RSVD))
        |=> (!mem_valid && !wb_en && !err)); // R2
    AST_POSTINC_STEP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'(AM_POSTINC) && size == 2'(SZ_LONG))
        |=> (wb_en && wb_data == ea + AW'(4))); // R4
    AST_PREDEC_SAME_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'(AM_PREDEC) && size != 2'(SZ_RSVD))
        |=> (wb_en && wb_data == ea && ea == $past(base) - $past(step_c))); // R5
    AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'(SZ_BYTE)) |=> !misaligned); // R8
    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (size == 2'(SZ_RSVD) || mode > 3'(AM_DISP)))
        |=> (err && !mem_valid && !wb_en && !misaligned)); // R9
endmodule

// File: tb/test_lsu_ea_gen.sv
`timescale 1ns/1ps
module test_lsu_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] base = '0;
    logic [3:0]  disp = '0;
    logic        out_valid, mem_valid, wb_en, misaligned, err;
    logic [31:0] ea, wb_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] regs [16];

    always #4 clk = ~clk;

    lsu_ea_gen i_lsu_ea_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .size(size), .base(base), .disp(disp), .out_valid(out_valid),
        .ea(ea), .mem_valid(mem_valid), .wb_en(wb_en), .wb_data(wb_data),
        .misaligned(misaligned), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full compare of one result, sampled at a falling edge.
    task automatic expect_res(input string req, input logic [31:0] e_ea,
                              input logic e_mem, input logic e_wb, input logic [31:0] e_wbd,
                              input logic e_mis, input logic e_err);
        chk({req, " out_valid"}, 32'(out_valid), 32'(1'b1));
        chk({req, " err"}, 32'(err), 32'(e_err));
        chk({req, " mem_valid"}, 32'(mem_valid), 32'(e_mem));
        chk({req, " wb_en"}, 32'(wb_en), 32'(e_wb));
        chk({req, " misaligned"}, 32'(misaligned), 32'(e_mis));
        if (e_mem) chk({req, " ea"}, ea, e_ea);
        if (e_wb)  chk({req, " wb_data"}, wb_data, e_wbd);
    endtask

    task automatic drive(input logic [2:0] m, input logic [1:0] s,
                         input logic [31:0] b, input logic [3:0] d);
        @(negedge clk);
        in_valid = 1'b1; mode = m; size = s; base = b; disp = d;
    endtask

    task automatic release_bus();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [2:0] m, input logic [1:0] s,
                          input logic [31:0] b, input logic [3:0] d, input logic [31:0] e_ea,
                          input logic e_mem, input logic e_wb, input logic [31:0] e_wbd,
                          input logic e_mis, input logic e_err);
        drive(m, s, b, d);
        release_bus();
        expect_res(req, e_ea, e_mem, e_wb, e_wbd, e_mis, e_err);
    endtask

    task automatic t_reset();
        chk("R1 reset out_valid", 32'(out_valid), 0);
        chk("R10 reset flags", 32'({mem_valid, wb_en, misaligned, err}), 0);
    endtask

    task automatic t_direct();
        run_op("R2 direct", 3'd0, 2'b10, 32'h1234_5678, 4'd3, 0, 0, 0, 0, 0, 0);
        chk("R2 direct ea", ea, 0);
    endtask

    task automatic t_indirect();
        run_op("R3 indirect", 3'd1, 2'b10, 32'h0000_1000, 4'd7, 32'h1000, 1, 0, 0, 0, 0);
    endtask

    task automatic t_postinc();
        run_op("R4 postinc byte", 3'd2, 2'b00, 32'h2001, 0, 32'h2001, 1, 1, 32'h2002, 0, 0);
        run_op("R4 postinc word", 3'd2, 2'b01, 32'h2000, 0, 32'h2000, 1, 1, 32'h2002, 0, 0);
        run_op("R4 postinc long", 3'd2, 2'b10, 32'h3000, 0, 32'h3000, 1, 1, 32'h3004, 0, 0);
    endtask

    task automatic t_predec();
        run_op("R5 predec long", 3'd3, 2'b10, 32'h100, 0, 32'hFC, 1, 1, 32'hFC, 0, 0);
        run_op("R5 predec word", 3'd3, 2'b01, 32'h100, 0, 32'hFE, 1, 1, 32'hFE, 0, 0);
        run_op("R5 predec byte", 3'd3, 2'b00, 32'h101, 0, 32'h100, 1, 1, 32'h100, 0, 0);
    endtask

    task automatic t_disp();
        run_op("R6 disp byte max", 3'd4, 2'b00, 32'h400, 4'hF, 32'h40F, 1, 0, 0, 0, 0);
        run_op("R6 disp word max", 3'd4, 2'b01, 32'h400, 4'hF, 32'h41E, 1, 0, 0, 0, 0);
        run_op("R6 disp long max", 3'd4, 2'b10, 32'h400, 4'hF, 32'h43C, 1, 0, 0, 0, 0);
        run_op("R6 disp zero", 3'd4, 2'b10, 32'h400, 4'h0, 32'h400, 1, 0, 0, 0, 0);
    endtask

    task automatic t_wrap();
        run_op("R7 postinc wrap", 3'd2, 2'b10, 32'hFFFF_FFFC, 0, 32'hFFFF_FFFC, 1, 1, 32'h0, 0, 0);
        run_op("R7 predec wrap", 3'd3, 2'b00, 32'h0, 0, 32'hFFFF_FFFF, 1, 1, 32'hFFFF_FFFF, 0, 0);
        run_op("R7 disp wrap", 3'd4, 2'b10, 32'hFFFF_FFF0, 4'd5, 32'h4, 1, 0, 0, 0, 0);
    endtask

    task automatic t_misalign();
        run_op("R8 word odd", 3'd1, 2'b01, 32'h1001, 0, 32'h1001, 1, 0, 0, 1, 0);
        run_op("R8 long half", 3'd1, 2'b10, 32'h1002, 0, 32'h1002, 1, 0, 0, 1, 0);
        run_op("R8 long disp", 3'd4, 2'b10, 32'h1001, 4'd1, 32'h1005, 1, 0, 0, 1, 0);
        run_op("R8 byte odd", 3'd1, 2'b00, 32'h1003, 0, 32'h1003, 1, 0, 0, 0, 0);
        run_op("R8 direct word odd", 3'd0, 2'b01, 32'h1001, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reserved();
        run_op("R9 size 11", 3'd2, 2'b11, 32'h5000, 0, 0, 0, 0, 0, 0, 1);
        run_op("R9 mode 5", 3'd5, 2'b10, 32'h5000, 0, 0, 0, 0, 0, 0, 1);
        run_op("R9 mode 7", 3'd7, 2'b00, 32'h5001, 0, 0, 0, 0, 0, 0, 1);
    endtask

    task automatic t_stream_and_drain();
        drive(3'd1, 2'b10, 32'hA000, 0);
        drive(3'd2, 2'b01, 32'hB000, 0);
        expect_res("R1 stream first", 32'hA000, 1, 0, 0, 0, 0);
        release_bus();
        expect_res("R1 stream second", 32'hB000, 1, 1, 32'hB002, 0, 0);
        @(negedge clk);
        chk("R1 drain out_valid", 32'(out_valid), 0);
        chk("R10 drain flags", 32'({mem_valid, wb_en, misaligned, err}), 0);
    endtask

    // Push three longwords on r15, then pop them back, applying each writeback.
    task automatic t_stack_bank();
        logic [31:0] seen [3];
        for (int i = 0; i < 16; i++) regs[i] = 32'h100 * i;
        regs[15] = 32'h800;
        for (int i = 0; i < 3; i++) begin
            drive(3'd3, 2'b10, regs[15], 0);
            release_bus();
            chk("R5 push ea", ea, 32'h800 - 32'(4 * (i + 1)));
            if (wb_en) regs[15] = wb_data;
        end
        chk("R5 bank after push", regs[15], 32'h7F4);
        for (int i = 0; i < 3; i++) begin
            drive(3'd2, 2'b10, regs[15], 0);
            release_bus();
            seen[i] = ea;
            if (wb_en) regs[15] = wb_data;
        end
        chk("R4 pop first ea", seen[0], 32'h7F4);
        chk("R4 pop last ea", seen[2], 32'h7FC);
        chk("R4 bank restored", regs[15], 32'h800);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_indirect();
        t_postinc();
        t_predec();
        t_disp();
        t_wrap();
        t_misalign();
        t_reserved();
        t_stream_and_drain();
        t_stack_bank();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule